// File: doc/BRIEF.md
# Flash Read Response Selector

This block produces the data returned for every read of a parallel NOR-style flash device. The write-side sequencer keeps the current command, and a separate status register holds the status byte. This block takes both as inputs. For each read request it returns one of four things: bytes from the storage array, the status byte, an identification code, or one byte of a parameter-defined query table.

The surrounding storage supplies a four-byte window that starts at the requested offset. The window holds the byte at the offset in bits 7:0, the next byte in bits 15:8, and so on. The block packs one, two or four of those bytes into the response in little- or big-endian order. Identification and query reads use an index taken from the low address byte, scaled down by the device's data width. A command value outside the known set is answered as an array read. In that case the block also pulses a flag so that the sequencer can drop back to array mode.

The response is registered. It is ready one clock after the request and stays unchanged until the next request.

Top module: `flash_rd_resp`

## Requirements
- R1: `rd_valid` is high exactly in the cycle after a cycle with `rd_req` high. After reset, `rd_valid`, `rd_data` and `mode_reset` are all zero.
- R2: With command 0x00, the response carries the window's bytes in little-endian order when `big_endian` is 0: byte at offset+k goes in bits 8k+7:8k. Size code 0 returns one byte, 1 returns two bytes, and 2 or 3 returns four bytes. All bits above the returned bytes are zero.
- R3: With command 0x00 and `big_endian` at 1, the byte at the offset is the most significant of the returned bytes, and later bytes follow in decreasing significance.
- R4: With any of the commands 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8 and a size code of 0 or 1, the response is the status byte in bits 7:0 with all other bits zero.
- R5: With one of the R4 commands and a size code of 2 or 3, the status byte appears in both bits 7:0 and bits 23:16, and the remaining bits are zero.
- R6: For identification and query reads, the index is the low 8 offset bits shifted right by 0, 1 or 2 for a device width of 1, 2 or 4 bytes.
- R7: With command 0x90, index 0 returns {ID0, ID1} in bits 15:0 and index 1 returns {ID2, ID3}. Every other index returns zero. The size code has no effect.
- R8: With command 0x98, an index no greater than QRY_LAST returns the table byte (index*QRY_MUL + QRY_ADD) mod 256 in bits 7:0. A larger index returns zero.
- R9: With any other command value, the response is that of an array read (R2, R3), and `mode_reset` is high together with `rd_valid`. For known commands `mode_reset` stays low.
- R10: In a cycle with no request, `rd_data` keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request strobe |
| rd_off | input | AW | Byte offset of the read |
| rd_size | input | 2 | Access size code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| big_endian | input | 1 | Pack array bytes most-significant first |
| cur_cmd | input | 8 | Command currently held by the write side |
| cur_status | input | 8 | Current status byte |
| arr_win | input | 32 | Storage bytes at offset..offset+3, lowest byte first |
| rd_valid | output | 1 | Response valid, one cycle after the request |
| rd_data | output | 32 | Response data |
| mode_reset | output | 1 | Unknown command seen: fall back to array read |

## Verification
The bench drives all 256 command values with every size code and both byte orders. This shows up two kinds of fault. A decode that puts one command in the wrong class returns a status byte where array data belongs, or the reverse. A missed unknown-command case leaves `mode_reset` low. Offsets are swept over two full wraps of the low address byte in ID and query mode. A wrong width scaling reads the wrong table entry. An off-by-one at the end of the query table gives a non-zero byte at index QRY_LAST+1, or zero at QRY_LAST. After each read the bench changes every input while holding the request low. A design that is not gated by the request then changes `rd_data` or raises `rd_valid`.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_IDENT  = 2'd2,
    SRC_QUERY  = 2'd3
  } rd_src_e;

  localparam logic [7:0] CMD_ARRAY = 8'h00;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_QUERY = 8'h98;

  // Commands whose reads return the status byte
  function automatic logic is_status_cmd(input logic [7:0] c);
    case (c)
      8'h10, 8'h20, 8'h28, 8'h40,
      8'h50, 8'h60, 8'h70, 8'hE8: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

  // Right shift turning a byte offset into a device-word index
  function automatic int unsigned width_shift(input int unsigned nbytes);
    if (nbytes >= 4) return 2;
    if (nbytes == 2) return 1;
    return 0;
  endfunction

  // Pack storage bytes (lowest address in bits 7:0) by size and order
  function automatic logic [31:0] pack_window(input logic [31:0] w,
                                              input logic [1:0]  sz,
                                              input logic        be);
    case (sz)
      2'd0:    return {24'h0, w[7:0]};
      2'd1:    return be ? {16'h0, w[7:0], w[15:8]} : {16'h0, w[15:0]};
      default: return be ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    endcase
  endfunction

  // Query table content for entry i
  function automatic logic [7:0] query_entry(input int unsigned i,
                                             input int unsigned mul,
                                             input int unsigned add);
    int unsigned v;
    v = i * mul + add;
    return v[7:0];
  endfunction

endpackage

// File: rtl/flash_rd_decode.sv
module flash_rd_decode
  import flash_rd_pkg::*;
(
  input  logic [7:0] cmd,
  output rd_src_e    src,
  output logic       unknown
);

  always_comb begin
    unknown = 1'b0;
    if (is_status_cmd(cmd)) begin
      src = SRC_STATUS;
    end else if (cmd == CMD_IDENT) begin
      src = SRC_IDENT;
    end else if (cmd == CMD_QUERY) begin
      src = SRC_QUERY;
    end else begin
      src     = SRC_ARRAY;
      unknown = (cmd != CMD_ARRAY);
    end
  end

endmodule

// File: rtl/flash_rd_array_pack.sv
module flash_rd_array_pack
  import flash_rd_pkg::*;
(
  input  logic [31:0] win,
  input  logic [1:0]  size,
  input  logic        be,
  output logic [31:0] packed_data
);

  assign packed_data = pack_window(win, size, be);

endmodule

// File: rtl/flash_rd_qry_rom.sv
module flash_rd_qry_rom
  import flash_rd_pkg::*;
#(
  parameter int unsigned QRY_LAST = 8'h51,
  parameter int unsigned QRY_MUL  = 29,
  parameter int unsigned QRY_ADD  = 8'h5A
) (
  input  logic [7:0] idx,
  output logic [7:0] q
);

  localparam int unsigned DEPTH = 256;

  logic [7:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    if (i <= QRY_LAST) begin : g_used
      assign rom[i] = query_entry(i, QRY_MUL, QRY_ADD);
    end else begin : g_empty
      assign rom[i] = 8'h00;
    end
  end

  assign q = rom[idx];

  // R8
  always_comb begin
    if (int'(idx) > QRY_LAST) begin
      query_oob_zero_chk: assert (q == 8'h00);
    end
  end

endmodule

// File: rtl/flash_rd_resp.sv
module flash_rd_resp
  import flash_rd_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DEV_BYTES = 2,
  parameter logic [7:0]  ID0       = 8'h89,
  parameter logic [7:0]  ID1       = 8'h00,
  parameter logic [7:0]  ID2       = 8'h17,
  parameter logic [7:0]  ID3       = 8'hC3,
  parameter int unsigned QRY_LAST  = 8'h51,
  parameter int unsigned QRY_MUL   = 29,
  parameter int unsigned QRY_ADD   = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_off,
  input  logic [1:0]    rd_size,
  input  logic          big_endian,
  input  logic [7:0]    cur_cmd,
  input  logic [7:0]    cur_status,
  input  logic [31:0]   arr_win,
  output logic          rd_valid,
  output logic [31:0]   rd_data,
  output logic          mode_reset
);

  localparam int unsigned IDX_SH = width_shift(DEV_BYTES);

  rd_src_e     src_sel;
  logic        cmd_unknown;
  logic [7:0]  word_idx;
  logic [31:0] array_word;
  logic [7:0]  query_byte;
  logic [31:0] ident_word;
  logic [31:0] status_word;
  logic [31:0] next_data;

  assign word_idx = rd_off[7:0] >> IDX_SH;

  flash_rd_decode i_decode (
    .cmd     (cur_cmd),
    .src     (src_sel),
    .unknown (cmd_unknown)
  );

  flash_rd_array_pack i_pack (
    .win         (arr_win),
    .size        (rd_size),
    .be          (big_endian),
    .packed_data (array_word)
  );

  flash_rd_qry_rom #(
    .QRY_LAST (QRY_LAST),
    .QRY_MUL  (QRY_MUL),
    .QRY_ADD  (QRY_ADD)
  ) i_rom (
    .idx (word_idx),
    .q   (query_byte)
  );

  always_comb begin
    case (word_idx)
      8'd0:    ident_word = {16'h0, ID0, ID1};
      8'd1:    ident_word = {16'h0, ID2, ID3};
      default: ident_word = 32'h0;
    endcase
  end

  assign status_word = {8'h0, (rd_size[1] ? cur_status : 8'h0), 8'h0, cur_status};

  always_comb begin
    case (src_sel)
      SRC_STATUS: next_data = status_word;
      SRC_IDENT:  next_data = ident_word;
      SRC_QUERY:  next_data = {24'h0, query_byte};
      default:    next_data = array_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= 32'h0;
      mode_reset <= 1'b0;
    end else begin
      rd_valid   <= rd_req;
      mode_reset <= rd_req & cmd_unknown;
      if (rd_req) rd_data <= next_data;
    end
  end

  // R1
  req_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  // R1
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data));

  // R9
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_reset |-> rd_valid);

  // R2
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_size == 2'd0 && src_sel == SRC_ARRAY) |=> (rd_data[31:8] == 24'h0));

  // R5
  status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && src_sel == SRC_STATUS && rd_size[1]) |=> (rd_data[23:16] == rd_data[7:0]));

endmodule

// File: tb/test_flash_rd_resp.sv
module test_flash_rd_resp;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DB = 2;
  localparam logic [7:0] I0 = 8'h89, I1 = 8'h00, I2 = 8'h17, I3 = 8'hC3;
  localparam int QL = 8'h51, QM = 29, QA = 8'h5A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_off = '0;
  logic [1:0]    rd_size = 2'd0;
  logic          big_endian = 1'b0;
  logic [7:0]    cur_cmd = 8'h00;
  logic [7:0]    cur_status = 8'h00;
  logic [31:0]   arr_win = 32'h0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic          mode_reset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rd_resp #(
    .AW(AW), .DEV_BYTES(DB), .ID0(I0), .ID1(I1), .ID2(I2), .ID3(I3),
    .QRY_LAST(QL), .QRY_MUL(QM), .QRY_ADD(QA)
  ) i_flash_rd_resp (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_off(rd_off),
    .rd_size(rd_size), .big_endian(big_endian), .cur_cmd(cur_cmd),
    .cur_status(cur_status), .arr_win(arr_win), .rd_valid(rd_valid),
    .rd_data(rd_data), .mode_reset(mode_reset)
  );

  function automatic logic [7:0] mem_byte(input int a);
    int v;
    v = a * 37 + 11;
    return v[7:0];
  endfunction

  function automatic bit known_cmd(input logic [7:0] c);
    return c == 8'h00 || c == 8'h10 || c == 8'h20 || c == 8'h28 || c == 8'h40 ||
           c == 8'h50 || c == 8'h60 || c == 8'h70 || c == 8'hE8 ||
           c == 8'h90 || c == 8'h98;
  endfunction

  function automatic bit stat_cmd(input logic [7:0] c);
    return known_cmd(c) && c != 8'h00 && c != 8'h90 && c != 8'h98;
  endfunction

  function automatic logic [31:0] model(input logic [7:0] c, input int off,
                                       input int sz, input bit be, input logic [7:0] st);
    int n, ix;
    logic [31:0] r;
    n  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    ix = (off % 256) / DB;
    r  = 32'h0;
    if (stat_cmd(c)) begin
      r = {24'h0, st};
      if (n == 4) r = r | ({24'h0, st} << 16);
    end else if (c == 8'h90) begin
      if (ix == 0) r = {16'h0, I0, I1};
      else if (ix == 1) r = {16'h0, I2, I3};
    end else if (c == 8'h98) begin
      if (ix <= QL) r = (ix * QM + QA) % 256;
    end else begin
      for (int k = 0; k < n; k++) begin
        if (be) r = r | ({24'h0, mem_byte(off + k)} << (8 * (n - 1 - k)));
        else    r = r | ({24'h0, mem_byte(off + k)} << (8 * k));
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] c, input int off, input int sz,
                         input bit be, input logic [7:0] st, input string tag);
    logic [31:0] e;
    logic [31:0] held;
    @(negedge clk);
    rd_req     = 1'b1;
    cur_cmd    = c;
    rd_off     = AW'(off);
    rd_size    = 2'(sz);
    big_endian = be;
    cur_status = st;
    arr_win    = {mem_byte(off + 3), mem_byte(off + 2), mem_byte(off + 1), mem_byte(off)};
    e = model(c, off, sz, be, st);
    @(negedge clk);
    chk(rd_valid == 1'b1, "R1", {31'h0, rd_valid}, 32'h1);
    chk(rd_data == e, tag, rd_data, e);
    chk(mode_reset == !known_cmd(c), "R9", {31'h0, mode_reset}, {31'h0, !known_cmd(c)});
    held = rd_data;
    rd_req     = 1'b0;
    cur_cmd    = ~c;
    rd_off     = ~rd_off;
    rd_size    = ~rd_size;
    big_endian = ~be;
    cur_status = ~st;
    arr_win    = ~arr_win;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1", {31'h0, rd_valid}, 32'h0);
    chk(rd_data == held, "R10", rd_data, held);
    chk(mode_reset == 1'b0, "R9", {31'h0, mode_reset}, 32'h0);
  endtask

  function automatic string tag_for(input logic [7:0] c, input int sz, input bit be);
    if (!known_cmd(c)) return "R9";
    if (c == 8'h90) return "R7";
    if (c == 8'h98) return "R8";
    if (stat_cmd(c)) return (sz >= 2) ? "R5" : "R4";
    return be ? "R3" : "R2";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd_valid == 1'b0, "R1", {31'h0, rd_valid}, 32'h0);
    chk(rd_data == 32'h0, "R1", rd_data, 32'h0);
    chk(mode_reset == 1'b0, "R1", {31'h0, mode_reset}, 32'h0);
    rst_n = 1'b1;

    // all commands x sizes x orders x a few offsets (R2 R3 R4 R5 R7 R8 R9)
    for (int c = 0; c < 256; c++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int be = 0; be < 2; be++) begin
          for (int oi = 0; oi < 4; oi++) begin
            int off;
            off = (oi == 0) ? 0 : (oi == 1) ? 2 : (oi == 2) ? 5 : 16'h01FF;
            do_read(8'(c), off, sz, be[0], 8'(c) ^ 8'hA5, tag_for(8'(c), sz, be[0]));
          end
        end
      end
    end

    // R6: index scaling sweep over two wraps of the low byte, ID and query modes
    for (int off = 0; off < 512; off++) begin
      do_read(8'h90, off, off % 4, 1'b0, 8'h3C, "R6");
      do_read(8'h98, off, off % 4, 1'b1, 8'h3C, "R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule